// File: doc/BRIEF.md
# Three-Wire DAC Mode-Word Serializer

This block loads a 16-bit control word into the mode port of an audio DAC. The port has three lines: a latch line, a data line and a bit clock. A one-cycle start strobe captures either the word on the input bus or a built-in power-up word, chosen by a select input. The block then shifts the word out most significant bit first. For each bit the clock is held low with the bit on the data line for one half-period, and then held high for one half-period. The latch line stays high for the whole shift.

After the last bit the data and clock lines go low. The latch line drops for one half-period to commit the word, then returns high for one more half-period. A one-cycle done pulse follows. The half-period is a parameter counted in system-clock cycles; 1000 cycles of a 100 MHz clock gives the 10 µs the DAC expects. The built-in word comes from a small composer that places a mode index and a word-length code into their fields and zeroes every other field.

Top module: `dac_mode_shifter`

## Requirements
- R1: While reset is asserted, and at idle, the latch line is high, the data and clock lines are low, and done is low.
- R2: The captured word leaves most significant bit first. Counting cycles from the edge that samples start, with H equal to HALF_CYC, bit 15-k is on the data line during cycles [2kH, 2kH+2H) for k = 0..15.
- R3: Within each bit slot the clock is low during the first H cycles and high during the second H cycles. The data line never changes while the clock stays high.
- R4: The latch line is high during the whole shift phase, cycles [0, 32H).
- R5: During cycles [32H, 33H) the latch line is low and the data and clock lines are low.
- R6: During cycles [33H, 34H) the latch line is high again with data and clock low and done low. Done is high for exactly cycle 34H, and the lines are then at their idle levels.
- R7: A start strobe that arrives during a transfer, in the shift phase or in the latch phase, has no effect on the waveform of that transfer.
- R8: A start strobe in the same cycle that done is high is accepted, so the next transfer begins at once.
- R9: With the select input high at start, the word shifted is the built-in word 0x1080: mode index 2 in bits [12:11], word-length code 2 (24-bit) in bits [7:6], and zero in all other bits.
- R10: The word is sampled only on the edge that accepts start. Later changes on the word bus do not alter the bits being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startStrobe | input | 1 | One-cycle request to send a word |
| useDefault | input | 1 | At start, selects the built-in power-up word instead of wordIn |
| wordIn | input | 16 | Control word to send |
| modeData | output | 1 | Serial data line to the DAC |
| modeClk | output | 1 | Bit clock to the DAC |
| modeLatch | output | 1 | Latch line to the DAC; idles high, a low pulse commits the word |
| done | output | 1 | One-cycle pulse when the transfer has finished |

## Verification
Two functions can fall in the same cycle: the done pulse that ends one transfer, and the acceptance of a new start strobe. The bench chains transfers by raising start on the cycle where done is expected. The next transfer must then show its first bit on the edge after the done cycle, checked against the same per-cycle waveform model. The other overlap is a start strobe that arrives during the shift and during the latch pulse. In that case the model expects the running waveform to be untouched, with no restart and no early done.

// File: rtl/dacser_pkg.sv
package dacser_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLK_LOW,
    ST_CLK_HIGH,
    ST_LATCH_LOW,
    ST_LATCH_HIGH
  } seqState_t;

  // Strobes from the sequencer to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic load;
    logic nextBit;
    logic raiseClk;
    logic enterLatch;
    logic releaseLatch;
    logic finish;
  } strobes_t;

endpackage

// File: rtl/dacser_word_compose.sv
module dacser_word_compose #(
  parameter int WORD_W   = 16,
  parameter int MODE_IDX = 2,
  parameter int LEN_CODE = 2
) (
  output logic [WORD_W-1:0] initWord
);
  localparam int MODE_LSB = 11;
  localparam int MODE_W   = 2;
  localparam int LEN_LSB  = 6;
  localparam int LEN_W    = 2;

  localparam logic [MODE_W-1:0] MODE_FIELD = MODE_W'(MODE_IDX);
  localparam logic [LEN_W-1:0]  LEN_FIELD  = LEN_W'(LEN_CODE);

  // Reset, mute, de-emphasis, zero-detect and attenuation fields stay zero.
  always_comb begin
    initWord = '0;
    initWord[MODE_LSB +: MODE_W] = MODE_FIELD;
    initWord[LEN_LSB +: LEN_W]   = LEN_FIELD;
  end

endmodule

// File: rtl/dacser_ctrl.sv
module dacser_ctrl
  import dacser_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int HALF_CYC = 1000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startStrobe,
  output strobes_t strb
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(WORD_W - 1);

  seqState_t state, stateNxt;
  logic [CNT_W-1:0] halfCnt;
  logic [BIT_W-1:0] bitCnt;
  logic halfEnd;

  assign halfEnd = (halfCnt == HALF_LAST);

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (startStrobe) begin
          strb.load = 1'b1;
          stateNxt  = ST_CLK_LOW;
        end
      end
      ST_CLK_LOW: begin
        if (halfEnd) begin
          strb.raiseClk = 1'b1;
          stateNxt      = ST_CLK_HIGH;
        end
      end
      ST_CLK_HIGH: begin
        if (halfEnd) begin
          if (bitCnt == BIT_LAST) begin
            strb.enterLatch = 1'b1;
            stateNxt        = ST_LATCH_LOW;
          end else begin
            strb.nextBit = 1'b1;
            stateNxt     = ST_CLK_LOW;
          end
        end
      end
      ST_LATCH_LOW: begin
        if (halfEnd) begin
          strb.releaseLatch = 1'b1;
          stateNxt          = ST_LATCH_HIGH;
        end
      end
      ST_LATCH_HIGH: begin
        if (halfEnd) begin
          strb.finish = 1'b1;
          stateNxt    = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE || halfEnd) begin
        halfCnt <= '0;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
      if (strb.load) begin
        bitCnt <= '0;
      end else if (strb.nextBit) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dacser_path.sv
module dacser_path
  import dacser_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [WORD_W-1:0] loadWord,
  output logic              modeData,
  output logic              modeClk,
  output logic              modeLatch,
  output logic              done
);
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      modeData  <= 1'b0;
      modeClk   <= 1'b0;
      modeLatch <= 1'b1;
      done      <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.load) begin
        shiftReg <= loadWord;
        modeData <= loadWord[WORD_W-1];
        modeClk  <= 1'b0;
      end else if (strb.nextBit) begin
        shiftReg <= shiftReg << 1;
        modeData <= shiftReg[WORD_W-2];
        modeClk  <= 1'b0;
      end else if (strb.raiseClk) begin
        modeClk <= 1'b1;
      end else if (strb.enterLatch) begin
        modeData  <= 1'b0;
        modeClk   <= 1'b0;
        modeLatch <= 1'b0;
      end else if (strb.releaseLatch) begin
        modeLatch <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dac_mode_shifter.sv
module dac_mode_shifter
  import dacser_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int HALF_CYC = 1000,
  parameter int MODE_IDX = 2,
  parameter int LEN_CODE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStrobe,
  input  logic              useDefault,
  input  logic [WORD_W-1:0] wordIn,
  output logic              modeData,
  output logic              modeClk,
  output logic              modeLatch,
  output logic              done
);
  strobes_t          strb;
  logic [WORD_W-1:0] initWord;
  logic [WORD_W-1:0] loadWord;

  dacser_word_compose #(
    .WORD_W  (WORD_W),
    .MODE_IDX(MODE_IDX),
    .LEN_CODE(LEN_CODE)
  ) compose_i (
    .initWord(initWord)
  );

  assign loadWord = useDefault ? initWord : wordIn;

  dacser_ctrl #(
    .WORD_W  (WORD_W),
    .HALF_CYC(HALF_CYC)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startStrobe(startStrobe),
    .strb       (strb)
  );

  dacser_path #(
    .WORD_W(WORD_W)
  ) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .loadWord (loadWord),
    .modeData (modeData),
    .modeClk  (modeClk),
    .modeLatch(modeLatch),
    .done     (done)
  );

endmodule

// File: rtl/dac_mode_shifter_chk.sv
module dac_mode_shifter_chk (
  input logic clk,
  input logic rstN,
  input logic modeData,
  input logic modeClk,
  input logic modeLatch,
  input logic done
);

  AST_DATA_STABLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (modeClk && $past(modeClk)) |-> $stable(modeData)); // R3

  AST_LATCH_HIGH_WHILE_CLOCKING: assert property (@(posedge clk) disable iff (!rstN)
    modeClk |-> modeLatch); // R4

  AST_LATCH_LOW_LINES_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !modeLatch |-> (!modeClk && !modeData)); // R5

  AST_DONE_AT_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (modeLatch && !modeClk && !modeData)); // R6

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_LATCH_RISE_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeLatch) |-> !modeClk); // R6

endmodule

bind dac_mode_shifter dac_mode_shifter_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .modeData (modeData),
  .modeClk  (modeClk),
  .modeLatch(modeLatch),
  .done     (done)
);

// File: tb/dac_mode_shifter_tb_top.sv
module dac_mode_shifter_tb_top;
  localparam int W = 16;
  localparam int H = 3;
  localparam int LAST = 34 * H;
  localparam logic [W-1:0] INIT_WORD = 16'h1080;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startStrobe = 1'b0;
  logic useDefault = 1'b0;
  logic [W-1:0] wordIn = '0;
  logic modeData, modeClk, modeLatch, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dac_mode_shifter #(.WORD_W(W), .HALF_CYC(H)) dut_i (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .useDefault(useDefault),
    .wordIn(wordIn), .modeData(modeData), .modeClk(modeClk),
    .modeLatch(modeLatch), .done(done)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b time=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chkIdle(input string req);
    chk(req, "latch", modeLatch, 1'b1);
    chk(req, "data", modeData, 1'b0);
    chk(req, "clock", modeClk, 1'b0);
    chk(req, "done", done, 1'b0);
  endtask

  // mode 0: plain, 1: start pulses mid-shift and mid-latch (R7), 2: word bus changes (R10)
  task automatic xfer(input logic [W-1:0] w, input logic def, input logic [W-1:0] expWord,
                      input int mode, input string dataReq);
    wordIn = w;
    useDefault = def;
    startStrobe = 1'b1;
    @(negedge clk);
    startStrobe = 1'b0;
    for (int n = 0; n <= LAST; n++) begin
      if (n < 32 * H) begin
        int slot = n / H;
        int k = slot / 2;
        chk(dataReq, "data bit", modeData, expWord[W-1-k]);
        chk("R3", "clock phase", modeClk, (slot % 2) == 1);
        chk("R4", "latch during shift", modeLatch, 1'b1);
        chk("R6", "done during shift", done, 1'b0);
      end else if (n < 33 * H) begin
        chk("R5", "latch pulse", modeLatch, 1'b0);
        chk("R5", "data in latch", modeData, 1'b0);
        chk("R5", "clock in latch", modeClk, 1'b0);
        chk("R6", "done in latch", done, 1'b0);
      end else if (n < LAST) begin
        chk("R6", "latch recovery", modeLatch, 1'b1);
        chk("R6", "data in recovery", modeData, 1'b0);
        chk("R6", "clock in recovery", modeClk, 1'b0);
        chk("R6", "done early", done, 1'b0);
      end else begin
        chk("R6", "done pulse", done, 1'b1);
        chk("R6", "latch at end", modeLatch, 1'b1);
        chk("R6", "data at end", modeData, 1'b0);
        chk("R6", "clock at end", modeClk, 1'b0);
      end
      if (mode == 1) begin
        if (n == 5 * H || n == 32 * H) begin
          startStrobe = 1'b1;
          wordIn = ~w;
          useDefault = ~def;
        end else begin
          startStrobe = 1'b0;
        end
      end else if (mode == 2 && n == H + 1) begin
        wordIn = ~w;
      end
      if (n < LAST) @(negedge clk);
    end
    startStrobe = 1'b0;
  endtask

  task automatic settle(input string req);
    @(negedge clk);
    chkIdle(req);
    @(negedge clk);
    chkIdle(req);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset levels
    @(negedge clk);
    chkIdle("R1");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1");

    // R2, R3: sweep of patterns, walking ones and walking zeros
    xfer(16'h0000, 1'b0, 16'h0000, 0, "R2");
    settle("R1");
    xfer(16'hFFFF, 1'b0, 16'hFFFF, 0, "R2");
    settle("R1");
    xfer(16'hA5C3, 1'b0, 16'hA5C3, 0, "R2");
    settle("R1");
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] one = W'(1) << i;
      xfer(one, 1'b0, one, 0, "R2");
      settle("R1");
      xfer(~one, 1'b0, ~one, 0, "R2");
      settle("R1");
    end

    // R9: built-in word, with a bus value that must not leak in
    xfer(16'h5A5A, 1'b1, INIT_WORD, 0, "R9");
    settle("R1");

    // R7: start strobes during shift and latch are ignored
    xfer(16'h3C96, 1'b0, 16'h3C96, 1, "R7");
    settle("R7");

    // R10: word bus changes after start have no effect
    xfer(16'hC001, 1'b0, 16'hC001, 2, "R10");
    settle("R10");

    // R8: chained transfers, each start lands on the done cycle
    xfer(16'h8421, 1'b0, 16'h8421, 0, "R2");
    xfer(16'h1248, 1'b0, 16'h1248, 0, "R8");
    xfer(16'h0000, 1'b1, INIT_WORD, 0, "R8");
    settle("R8");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule